// File: doc/BRIEF.md
# Mixed-Sign Multi-Mode Multiplier

This block forms a 32-bit product from two 16-bit operands using a single signed 17-by-17 multiply array. Each operand is widened to 17 bits before it reaches the array. A signed operand copies its top bit into the new bit. An unsigned operand gets a zero there. Because of this, one signed array produces signed, unsigned and mixed-sign products. The second operand can instead come from a 5-bit unsigned literal. A separate byte-size input selects an unsigned 8-by-8 product.

Operands enter through a valid/ready input channel, and the product leaves through a valid/ready output channel. Between them sits one register slot. An operation is accepted on a rising clock edge where `in_valid` and `in_ready` are both high. Its product appears on `product` with `out_valid` high from the next cycle on. While `out_valid` is high and `out_ready` is low, the product is held, and `in_ready` is low, so no new operation enters. When the slot is empty, or is being drained in the same cycle, `in_ready` is high. This gives one operation per cycle when the consumer does not stall.

Top module: `mixmul_top`

## Requirements
- R1: While `rst_n` is low, and after it is released, `out_valid` is 0 and `in_ready` is 1 until the first operation is accepted.
- R2: With `mode` 0 (signed by signed) and `narrow` 0, `product` is the two's-complement product of `op_a` and `op_b`, both taken as signed.
- R3: With `mode` 1 (unsigned by unsigned), `product` is the unsigned product of `op_a` and `op_b`. Codes 6 and 7 behave the same as code 1.
- R4: With `mode` 2, `op_a` is taken as unsigned and `op_b` as signed, and `product` is their two's-complement product.
- R5: With `mode` 3, `op_a` is taken as signed and `op_b` as unsigned, and `product` is their two's-complement product.
- R6: With `mode` 4 (signed `op_a`) or `mode` 5 (unsigned `op_a`), the second factor is `lit` read as an unsigned value from 0 to 31, and `op_b` has no effect on `product`.
- R7: With `narrow` 1, `product` is the unsigned product of `op_a[7:0]` and `op_b[7:0]`, so `product[31:16]` is 0. In this case `mode` and the upper bytes of both operands have no effect.
- R8: An operation accepted on a clock edge gives `out_valid` 1 and its product on `product` after that edge.
- R9: While `out_valid` is 1 and `out_ready` is 0, `product` and `out_valid` keep their values and `in_ready` is 0.
- R10: `in_ready` is 1 whenever `out_valid` is 0 or `out_ready` is 1, so a new operation can be accepted in the same cycle the held product is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An operation is presented |
| in_ready | output | 1 | The slot can take an operation this cycle |
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand (register form) |
| lit | input | 5 | Unsigned literal second operand |
| mode | input | 3 | Signedness / source select, codes 0..7 |
| narrow | input | 1 | 1 selects unsigned byte-by-byte product |
| out_valid | output | 1 | `product` holds an untaken result |
| out_ready | input | 1 | Consumer takes the product this cycle |
| product | output | 32 | Low 32 bits of the exact product |

## Verification
The assertions assume only that `in_valid`, `out_ready`, `narrow` and `mode` are known (not X) on every clock edge after reset. They do not assume that the producer holds its operands steady while it is stalled, and the bench deliberately changes the operands during a stall. The bench drives every input on the falling clock edge and samples `product` and the handshake outputs on the next falling edge. This keeps each input stable around the rising edge that accepts it. The expected product comes from a 64-bit reference that extends each factor according to the requirement for its mode.

// File: rtl/mixmul_pkg.sv
package mixmul_pkg;

  // Operation selector; the code values are part of the interface.
  typedef enum logic [2:0] {
    MM_SS  = 3'd0,  // signed   x signed
    MM_UU  = 3'd1,  // unsigned x unsigned
    MM_US  = 3'd2,  // unsigned x signed
    MM_SU  = 3'd3,  // signed   x unsigned
    MM_SL  = 3'd4,  // signed   x literal
    MM_UL  = 3'd5,  // unsigned x literal
    MM_RS6 = 3'd6,  // spare, acts as unsigned x unsigned
    MM_RS7 = 3'd7   // spare, acts as unsigned x unsigned
  } mm_mode_e;

  // Per-operand extension decision.
  typedef struct packed {
    logic a_signed;
    logic b_signed;
    logic b_literal;
  } mm_ctl_t;

  function automatic mm_ctl_t mm_decode(input mm_mode_e m);
    mm_ctl_t c;
    c = '{a_signed: 1'b0, b_signed: 1'b0, b_literal: 1'b0};
    case (m)
      MM_SS: begin c.a_signed = 1'b1; c.b_signed = 1'b1; end
      MM_US: c.b_signed = 1'b1;
      MM_SU: c.a_signed = 1'b1;
      MM_SL: begin c.a_signed = 1'b1; c.b_literal = 1'b1; end
      MM_UL: c.b_literal = 1'b1;
      default: ;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/mixmul_extend.sv
module mixmul_extend
  import mixmul_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int LIT_W    = 5,
  parameter int NARROW_W = 8
) (
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [LIT_W-1:0]  lit,
  input  mm_mode_e          mode,
  input  logic              narrow,
  output logic [DATA_W:0]   a_ext,
  output logic [DATA_W:0]   b_ext
);

  localparam int PAD_N = DATA_W - NARROW_W;
  localparam int PAD_L = DATA_W + 1 - LIT_W;

  mm_ctl_t ctl;
  logic [DATA_W-1:0] a_src;
  logic [DATA_W-1:0] b_src;
  logic              a_sx;
  logic              b_sx;

  always_comb begin
    ctl = mm_decode(mode);
    if (narrow) begin
      a_src = {{PAD_N{1'b0}}, op_a[NARROW_W-1:0]};
      b_src = {{PAD_N{1'b0}}, op_b[NARROW_W-1:0]};
      a_sx  = 1'b0;
      b_sx  = 1'b0;
    end else begin
      a_src = op_a;
      b_src = op_b;
      a_sx  = ctl.a_signed & op_a[DATA_W-1];
      b_sx  = ctl.b_signed & op_b[DATA_W-1];
    end
    a_ext = {a_sx, a_src};
    if (!narrow && ctl.b_literal) b_ext = {{PAD_L{1'b0}}, lit};
    else                          b_ext = {b_sx, b_src};
  end

endmodule

// File: rtl/mixmul_core.sv
module mixmul_core #(
  parameter int DATA_W = 16,
  parameter int PROD_W = 32
) (
  input  logic [DATA_W:0]   a_ext,
  input  logic [DATA_W:0]   b_ext,
  output logic [PROD_W-1:0] prod
);

  // Both factors are signed DATA_W+1 bit values; evaluating at PROD_W
  // yields the low PROD_W bits of the exact 2*(DATA_W+1) bit product.
  logic signed [PROD_W-1:0] p_s;

  always_comb begin
    p_s  = $signed(a_ext) * $signed(b_ext);
    prod = p_s;
  end

endmodule

// File: rtl/mixmul_slot.sv
module mixmul_slot #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);

  logic          vld_q;
  logic [DW-1:0] dat_q;

  assign in_ready  = !vld_q || out_ready;
  assign out_valid = vld_q;
  assign out_data  = dat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else if (in_ready) begin
      vld_q <= in_valid;
      if (in_valid) dat_q <= in_data;
    end
  end

endmodule

// File: rtl/mixmul_top.sv
module mixmul_top
  import mixmul_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int LIT_W    = 5,
  parameter int NARROW_W = 8,
  localparam int PROD_W  = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [LIT_W-1:0]  lit,
  input  logic [2:0]        mode,
  input  logic              narrow,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PROD_W-1:0] product
);

  logic [DATA_W:0]   a_ext;
  logic [DATA_W:0]   b_ext;
  logic [PROD_W-1:0] prod_c;

  mixmul_extend #(
    .DATA_W(DATA_W), .LIT_W(LIT_W), .NARROW_W(NARROW_W)
  ) u_ext (
    .op_a(op_a), .op_b(op_b), .lit(lit),
    .mode(mm_mode_e'(mode)), .narrow(narrow),
    .a_ext(a_ext), .b_ext(b_ext)
  );

  mixmul_core #(.DATA_W(DATA_W), .PROD_W(PROD_W)) u_core (
    .a_ext(a_ext), .b_ext(b_ext), .prod(prod_c)
  );

  mixmul_slot #(.DW(PROD_W)) u_slot (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(prod_c),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(product)
  );

endmodule

// File: rtl/mixmul_chk.sv
module mixmul_chk #(
  parameter int DATA_W = 16,
  parameter int LIT_W  = 5,
  localparam int PROD_W = 2 * DATA_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DATA_W-1:0] op_a,
  input logic [DATA_W-1:0] op_b,
  input logic [LIT_W-1:0]  lit,
  input logic [2:0]        mode,
  input logic              narrow,
  input logic              out_valid,
  input logic              out_ready,
  input logic [PROD_W-1:0] product
);

  p_reset_idle_r1: assert property (@(posedge clk) !rst_n |=> !out_valid);

  p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(product));

  p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  p_free_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid || out_ready |-> in_ready);

  p_narrow_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && narrow |=> product[PROD_W-1:DATA_W] == '0);

endmodule

bind mixmul_top mixmul_chk #(.DATA_W(DATA_W), .LIT_W(LIT_W)) u_chk (.*);

// File: tb/test_mixmul_top.sv
`timescale 1ns/1ps
module test_mixmul_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [15:0] op_a;
  logic [15:0] op_b;
  logic [4:0]  lit;
  logic [2:0]  mode;
  logic        narrow;
  logic        out_valid;
  logic        out_ready;
  logic [31:0] product;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  mixmul_top i_mixmul_top (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_a(op_a), .op_b(op_b), .lit(lit), .mode(mode), .narrow(narrow),
    .out_valid(out_valid), .out_ready(out_ready), .product(product)
  );

  // Vector fields: [40:38] mode, [37] narrow, [36:21] a, [20:5] b, [4:0] lit
  localparam logic [40:0] VEC [14] = '{
    {3'd0, 1'b0, 16'h7FFF, 16'h7FFF, 5'd0},   // R2 max positive
    {3'd0, 1'b0, 16'h8000, 16'h8000, 5'd0},   // R2 most negative squared
    {3'd0, 1'b0, 16'hFFF3, 16'h0045, 5'd0},   // R2 mixed signs
    {3'd1, 1'b0, 16'hFFFF, 16'hFFFF, 5'd0},   // R3
    {3'd6, 1'b0, 16'h9ABC, 16'hDEF0, 5'd0},   // R3 spare code
    {3'd7, 1'b0, 16'h8001, 16'h0003, 5'd0},   // R3 spare code
    {3'd2, 1'b0, 16'hF000, 16'h8000, 5'd0},   // R4
    {3'd2, 1'b0, 16'h1234, 16'hFFFE, 5'd0},   // R4
    {3'd3, 1'b0, 16'h8000, 16'hFFFF, 5'd0},   // R5
    {3'd3, 1'b0, 16'h0007, 16'hC000, 5'd0},   // R5
    {3'd4, 1'b0, 16'hFFFE, 16'h5555, 5'd31},  // R6 signed x literal
    {3'd5, 1'b0, 16'hC000, 16'hAAAA, 5'd17},  // R6 unsigned x literal
    {3'd0, 1'b1, 16'hFFFF, 16'hFFFF, 5'd0},   // R7 byte max
    {3'd4, 1'b1, 16'h3380, 16'h7781, 5'd9}    // R7 mode ignored
  };

  function automatic logic [31:0] ref_prod(input logic [2:0] m, input logic nb,
      input logic [15:0] a, input logic [15:0] b, input logic [4:0] l);
    longint sa, ua, sb, ub, x, y, p;
    sa = longint'($signed(a)); ua = longint'({48'd0, a});
    sb = longint'($signed(b)); ub = longint'({48'd0, b});
    if (nb) begin
      x = longint'({56'd0, a[7:0]}); y = longint'({56'd0, b[7:0]});
    end else begin
      case (m)
        3'd0: begin x = sa; y = sb; end
        3'd2: begin x = ua; y = sb; end
        3'd3: begin x = sa; y = ub; end
        3'd4: begin x = sa; y = longint'({59'd0, l}); end
        3'd5: begin x = ua; y = longint'({59'd0, l}); end
        default: begin x = ua; y = ub; end
      endcase
    end
    p = x * y;
    return p[31:0];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] m, input logic nb, input logic [15:0] a,
      input logic [15:0] b, input logic [4:0] l);
    mode = m; narrow = nb; op_a = a; op_b = b; lit = l; in_valid = 1'b1;
  endtask

  // Send one operation with a free consumer and check its product.
  task automatic run_op(input string req, input logic [2:0] m, input logic nb,
      input logic [15:0] a, input logic [15:0] b, input logic [4:0] l,
      input logic [31:0] exp);
    @(negedge clk);
    out_ready = 1'b1;
    drive(m, nb, a, b, l);
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " out_valid"}, {31'd0, out_valid}, 32'd1);
    check({req, " product"}, product, exp);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    op_a = '0; op_b = '0; lit = '0; mode = '0; narrow = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 out_valid in reset", {31'd0, out_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 out_valid after reset", {31'd0, out_valid}, 32'd0);
    check("R1 in_ready after reset", {31'd0, in_ready}, 32'd1);

    for (int i = 0; i < 14; i++) begin
      logic [40:0] v;
      v = VEC[i];
      run_op($sformatf("vec%0d", i), v[40:38], v[37], v[36:21], v[20:5], v[4:0],
             ref_prod(v[40:38], v[37], v[36:21], v[20:5], v[4:0]));
    end

    // Hand-computed corners
    run_op("R2 -1*-1", 3'd0, 1'b0, 16'hFFFF, 16'hFFFF, 5'd0, 32'h0000_0001);
    run_op("R3 max*max", 3'd1, 1'b0, 16'hFFFF, 16'hFFFF, 5'd0, 32'hFFFE_0001);
    run_op("R4 u*s", 3'd2, 1'b0, 16'hFFFF, 16'hFFFF, 5'd0, 32'hFFFF_0001);
    run_op("R5 s*u", 3'd3, 1'b0, 16'hFFFF, 16'hFFFF, 5'd0, 32'hFFFF_0001);
    run_op("R6 min*31", 3'd4, 1'b0, 16'h8000, 16'h7777, 5'd31, 32'hFFF0_8000);
    run_op("R6 op_b ignored", 3'd5, 1'b0, 16'hFFFF, 16'h1234, 5'd31, 32'h001E_FFE1);
    run_op("R6 op_b ignored alt", 3'd5, 1'b0, 16'hFFFF, 16'hFEDC, 5'd31, 32'h001E_FFE1);
    run_op("R7 upper bytes ignored", 3'd0, 1'b1, 16'hAB12, 16'hCD34, 5'd0, 32'h0000_03A8);

    // R9 and R10: back-pressure then drain with same-cycle refill
    @(negedge clk);
    out_ready = 1'b0;
    drive(3'd1, 1'b0, 16'h0100, 16'h0100, 5'd0);      // 0x0001_0000
    @(negedge clk);
    check("R8 out_valid", {31'd0, out_valid}, 32'd1);
    check("R9 in_ready low while stalled", {31'd0, in_ready}, 32'd0);
    drive(3'd1, 1'b0, 16'h0003, 16'h0005, 5'd0);      // 15, must wait
    @(negedge clk);
    check("R9 product held", product, 32'h0001_0000);
    check("R9 out_valid held", {31'd0, out_valid}, 32'd1);
    out_ready = 1'b1;
    #0.1;
    check("R10 in_ready with out_ready", {31'd0, in_ready}, 32'd1);
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 refill product", product, 32'h0000_000F);
    check("R10 refill out_valid", {31'd0, out_valid}, 32'd1);
    @(negedge clk);
    check("R8 drained", {31'd0, out_valid}, 32'd0);

    // R1: reset mid-stall clears the slot
    out_ready = 1'b0;
    drive(3'd1, 1'b0, 16'h0002, 16'h0002, 5'd0);
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 reset clears held result", {31'd0, out_valid}, 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule